// File: doc/BRIEF.md
# Bank latch and address decoder

This block sits beside a processor that has a 16-bit address bus and sends the top eight bits of a 24-bit address over its data lines during the low half of the phase-2 clock. A transparent latch captures that bank byte while phase-2 is low and holds it through the high half, when the data lines carry data. The latched bank is joined with the 16-bit address to form the full 24-bit address.

The same logic decodes the address into active-low selects for RAM, an I/O window and ROM. Each select is qualified by the processor's two valid-address outputs, one for data cycles and one for program cycles, so that idle bus cycles cannot cause false accesses. No select is qualified by phase-2, so every select is settled before phase-2 rises. The I/O window is split into sixteen 1 KB device selects. One of these slots also drives the enable of a peripheral bus transceiver, and the transceiver's direction follows the read/write line.

Top module: `bank_addr_decoder`

## Requirements
- R1: While `phase_clk` is low, `bank` follows `dbus`. While `phase_clk` is high, `bank` keeps the value it had at the rising edge, whatever `dbus` does.
- R2: While `rst_n` is low, `bank` is forced to 0. If reset is released while `phase_clk` is high, `bank` stays 0 until `phase_clk` next goes low.
- R3: When `data_valid_adr` and `prog_valid_adr` are both low, `ram_sel_n`, `io_sel_n`, `rom_sel_n`, every bit of `dev_sel_n` and `xcvr_en_n` are all high. Either strobe alone is enough to allow a select.
- R4: With bank 0 and a strobe high, address 0x0000–0x7FFF drives `ram_sel_n` low, 0x8000–0xBFFF drives `io_sel_n` low, and 0xC000–0xFFFF drives `rom_sel_n` low. At most one of the three is ever low.
- R5: Selects do not depend on `phase_clk`. The same bank, address and strobes give the same selects in both halves of the cycle.
- R6: With a nonzero bank, no select is asserted when `MIRROR_HIGH_BANKS` is 0. When it is 1, every bank decodes exactly as bank 0.
- R7: Inside the I/O window, `dev_sel_n[k]` is low for k = address bits 13..10 (1 KB per device, k = 0 at 0x8000). At most one bit is low, and only while `io_sel_n` is low.
- R8: `xcvr_en_n` is low exactly when `dev_sel_n[XCVR_SLOT]` is low. The default slot is 15 (0xBC00–0xBFFF). At all other times the transceiver stays disabled, whatever the phase.
- R9: `xcvr_to_cpu` equals `cpu_read` at all times (1 = read, drive toward the processor; 0 = write, drive toward the device).
- R10: `full_adr` equals `bank` in bits 23..16 and `adr` in bits 15..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_clk | input | 1 | Phase-2 bus clock; low half carries the bank byte |
| rst_n | input | 1 | Active-low reset; clears the bank latch |
| cpu_read | input | 1 | 1 = read cycle, 0 = write cycle |
| data_valid_adr | input | 1 | Address is valid for a data access |
| prog_valid_adr | input | 1 | Address is valid for a program access |
| adr | input | 16 | Processor address bus |
| dbus | input | 8 | Processor data bus (bank byte while phase_clk is low) |
| bank | output | 8 | Latched bank byte |
| full_adr | output | 24 | Bank and address joined |
| ram_sel_n | output | 1 | RAM select, active low |
| io_sel_n | output | 1 | I/O window select, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| dev_sel_n | output | 16 | Per-device 1 KB selects inside the I/O window, active low |
| xcvr_en_n | output | 1 | Peripheral transceiver enable, active low |
| xcvr_to_cpu | output | 1 | Transceiver direction, 1 = toward the processor |

## Verification
The only state in the block is the bank latch. A latch that tracks the data bus during the high half, or that misses a value during the low half, shows up on `bank` and `full_adr` at once, in the same half-cycle. Because the decode is gated by bank 0, a wrong bank also makes every select drop or appear in that same half-cycle. The reference model therefore tracks the bank on every bench clock and compares all outputs on every clock. A decoy byte is placed on the bus early in each low phase and write data late in each high phase, so that an error in either latch phase shows up within one bench clock.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_RAM  = 2'd1,
      RGN_IO   = 2'd2,
      RGN_ROM  = 2'd3
   } region_e;

   typedef struct packed {
      logic ram;
      logic io;
      logic rom;
   } region_sel_t;

   function automatic region_sel_t sel_of(input region_e r);
      region_sel_t s;
      s = '0;
      unique case (r)
         RGN_RAM:  s.ram = 1'b1;
         RGN_IO:   s.io  = 1'b1;
         RGN_ROM:  s.rom = 1'b1;
         default:  s     = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/bank_latch.sv
module bank_latch #(
   parameter int unsigned BANK_W = 8
) (
   input  logic              phase_clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] dbus,
   output logic [BANK_W-1:0] bank
);

   // Open while the phase clock is low, closed while it is high.
   always_latch begin
      if (!rst_n)
         bank = '0;
      else if (!phase_clk)
         bank = dbus;
   end

   // Edge-captured copy of the bus, used only to check the hold phase.
   logic [BANK_W-1:0] cap_q;
   logic              cap_vld;

   always_ff @(posedge phase_clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q   <= '0;
         cap_vld <= 1'b0;
      end else begin
         cap_q   <= dbus;
         cap_vld <= 1'b1;
      end
   end

   AST_BANK_HOLD: assert property (@(negedge phase_clk) disable iff (!rst_n)
      cap_vld |-> (bank == cap_q)); // R1

endmodule

// File: rtl/region_decode.sv
module region_decode
   import bank_dec_pkg::*;
#(
   parameter int unsigned ADDR_W            = 16,
   parameter int unsigned BANK_W            = 8,
   parameter int unsigned RAM_LIMIT         = 32'h8000,
   parameter int unsigned IO_LIMIT          = 32'hC000,
   parameter bit          MIRROR_HIGH_BANKS = 1'b0
) (
   input  logic              phase_clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank,
   input  logic [ADDR_W-1:0] adr,
   input  logic              data_valid_adr,
   input  logic              prog_valid_adr,
   output region_sel_t       sel,
   output logic              io_hit
);

   localparam logic [ADDR_W:0] RAM_END = (ADDR_W+1)'(RAM_LIMIT);
   localparam logic [ADDR_W:0] IO_END  = (ADDR_W+1)'(IO_LIMIT);

   logic    strobe_ok;
   logic    bank_ok;
   region_e rgn;

   assign strobe_ok = data_valid_adr | prog_valid_adr;
   assign bank_ok   = MIRROR_HIGH_BANKS || (bank == '0);

   // Region choice never looks at the phase clock.
   always_comb begin
      if (!(strobe_ok && bank_ok))
         rgn = RGN_NONE;
      else if ({1'b0, adr} < RAM_END)
         rgn = RGN_RAM;
      else if ({1'b0, adr} < IO_END)
         rgn = RGN_IO;
      else
         rgn = RGN_ROM;
   end

   assign sel    = sel_of(rgn);
   assign io_hit = sel.io;

   AST_STROBE_GATE: assert property (@(posedge phase_clk) disable iff (!rst_n)
      !(data_valid_adr || prog_valid_adr) |-> (sel == '0)); // R3

   AST_ONE_REGION: assert property (@(posedge phase_clk) disable iff (!rst_n)
      $onehot0(sel)); // R4

   AST_HIGH_BANK_QUIET: assert property (@(posedge phase_clk) disable iff (!rst_n)
      (!MIRROR_HIGH_BANKS && (bank != '0)) |-> (sel == '0)); // R6

endmodule

// File: rtl/io_subdecode.sv
module io_subdecode #(
   parameter int unsigned SUB_W = 4,
   localparam int unsigned SUB_N = 1 << SUB_W
) (
   input  logic             phase_clk,
   input  logic             rst_n,
   input  logic             io_hit,
   input  logic [SUB_W-1:0] idx,
   output logic [SUB_N-1:0] sub_sel
);

   for (genvar k = 0; k < SUB_N; k++) begin : g_slot
      assign sub_sel[k] = io_hit && (idx == SUB_W'(k));
   end

   AST_SUB_ONEHOT: assert property (@(posedge phase_clk) disable iff (!rst_n)
      $onehot0(sub_sel)); // R7

   AST_SUB_NEEDS_IO: assert property (@(posedge phase_clk) disable iff (!rst_n)
      (|sub_sel) |-> io_hit); // R7

endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
   import bank_dec_pkg::*;
#(
   parameter int unsigned ADDR_W            = 16,
   parameter int unsigned BANK_W            = 8,
   parameter int unsigned RAM_LIMIT         = 32'h8000,
   parameter int unsigned IO_LIMIT          = 32'hC000,
   parameter int unsigned IO_SUB_W          = 4,
   parameter int unsigned IO_SUB_LSB        = 10,
   parameter int unsigned XCVR_SLOT         = 15,
   parameter bit          MIRROR_HIGH_BANKS = 1'b0,
   localparam int unsigned SUB_N  = 1 << IO_SUB_W,
   localparam int unsigned FULL_W = ADDR_W + BANK_W
) (
   input  logic              phase_clk,
   input  logic              rst_n,
   input  logic              cpu_read,
   input  logic              data_valid_adr,
   input  logic              prog_valid_adr,
   input  logic [ADDR_W-1:0] adr,
   input  logic [BANK_W-1:0] dbus,
   output logic [BANK_W-1:0] bank,
   output logic [FULL_W-1:0] full_adr,
   output logic              ram_sel_n,
   output logic              io_sel_n,
   output logic              rom_sel_n,
   output logic [SUB_N-1:0]  dev_sel_n,
   output logic              xcvr_en_n,
   output logic              xcvr_to_cpu
);

   localparam longint unsigned WIN_BYTES = longint'(1) << (IO_SUB_LSB + IO_SUB_W);
   localparam longint unsigned ADR_SPAN  = longint'(1) << ADDR_W;

   // Elaboration-time parameter checks.
   if (IO_LIMIT <= RAM_LIMIT) begin : g_chk_order
      $error("I/O limit must lie above the RAM limit");
   end
   if (longint'(IO_LIMIT) > ADR_SPAN) begin : g_chk_span
      $error("I/O limit exceeds the address space");
   end
   if (longint'(IO_LIMIT - RAM_LIMIT) != WIN_BYTES) begin : g_chk_win
      $error("I/O window size must equal device count times device size");
   end
   if ((longint'(RAM_LIMIT) % WIN_BYTES) != 0) begin : g_chk_align
      $error("I/O window must be aligned to its own size");
   end
   if (IO_SUB_LSB + IO_SUB_W > ADDR_W) begin : g_chk_bits
      $error("device index bits fall outside the address bus");
   end
   if (XCVR_SLOT >= SUB_N) begin : g_chk_slot
      $error("transceiver slot is outside the device range");
   end

   region_sel_t          sel;
   logic                 io_hit;
   logic [SUB_N-1:0]     sub_sel;

   bank_latch #(
      .BANK_W (BANK_W)
   ) u_latch (
      .phase_clk (phase_clk),
      .rst_n     (rst_n),
      .dbus      (dbus),
      .bank      (bank)
   );

   region_decode #(
      .ADDR_W            (ADDR_W),
      .BANK_W            (BANK_W),
      .RAM_LIMIT         (RAM_LIMIT),
      .IO_LIMIT          (IO_LIMIT),
      .MIRROR_HIGH_BANKS (MIRROR_HIGH_BANKS)
   ) u_region (
      .phase_clk      (phase_clk),
      .rst_n          (rst_n),
      .bank           (bank),
      .adr            (adr),
      .data_valid_adr (data_valid_adr),
      .prog_valid_adr (prog_valid_adr),
      .sel            (sel),
      .io_hit         (io_hit)
   );

   io_subdecode #(
      .SUB_W (IO_SUB_W)
   ) u_sub (
      .phase_clk (phase_clk),
      .rst_n     (rst_n),
      .io_hit    (io_hit),
      .idx       (adr[IO_SUB_LSB +: IO_SUB_W]),
      .sub_sel   (sub_sel)
   );

   assign full_adr    = {bank, adr};
   assign ram_sel_n   = ~sel.ram;
   assign io_sel_n    = ~sel.io;
   assign rom_sel_n   = ~sel.rom;
   assign dev_sel_n   = ~sub_sel;

   // Transceiver: enabled only for its own device slot, never by phase.
   assign xcvr_en_n   = ~sub_sel[XCVR_SLOT];
   assign xcvr_to_cpu = cpu_read;

   AST_XCVR_IN_IO: assert property (@(posedge phase_clk) disable iff (!rst_n)
      !xcvr_en_n |-> !io_sel_n); // R8

endmodule

// File: tb/bank_addr_decoder_test.sv
`timescale 1ns/1ps
module bank_addr_decoder_test;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, phase_clk, cpu_read, dv, pv;
   logic [15:0] adr;
   logic [7:0]  dbus;

   logic [7:0]  bank_a, bank_b;
   logic [23:0] full_a, full_b;
   logic        ram_a, io_a, rom_a, en_a, dir_a;
   logic        ram_b, io_b, rom_b, en_b, dir_b;
   logic [15:0] dev_a, dev_b;

   bank_addr_decoder uut (
      .phase_clk(phase_clk), .rst_n(rst_n), .cpu_read(cpu_read),
      .data_valid_adr(dv), .prog_valid_adr(pv), .adr(adr), .dbus(dbus),
      .bank(bank_a), .full_adr(full_a), .ram_sel_n(ram_a), .io_sel_n(io_a),
      .rom_sel_n(rom_a), .dev_sel_n(dev_a), .xcvr_en_n(en_a), .xcvr_to_cpu(dir_a));

   bank_addr_decoder #(.MIRROR_HIGH_BANKS(1'b1)) uut_mirror (
      .phase_clk(phase_clk), .rst_n(rst_n), .cpu_read(cpu_read),
      .data_valid_adr(dv), .prog_valid_adr(pv), .adr(adr), .dbus(dbus),
      .bank(bank_b), .full_adr(full_b), .ram_sel_n(ram_b), .io_sel_n(io_b),
      .rom_sel_n(rom_b), .dev_sel_n(dev_b), .xcvr_en_n(en_b), .xcvr_to_cpu(dir_b));

   int checks = 0;
   int errors = 0;
   int ref_bank = 0;
   bit finished = 1'b0;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h (adr=%0h phase=%0b)",
                  tag, what, act, exp, adr, phase_clk);
      end
   endtask

   // Behavioural reference for one instance.
   task automatic compare(bit mirror, int b, int f, int ram, int io, int rom,
                          int dev, int en, int dir);
      int a = int'(adr);
      bit valid = dv || pv;
      bit bok = mirror || (ref_bank == 0);
      bit hit = valid && bok;
      int e_ram = (hit && a < 32768) ? 0 : 1;
      int e_io  = (hit && a >= 32768 && a < 49152) ? 0 : 1;
      int e_rom = (hit && a >= 49152) ? 0 : 1;
      int slot  = (e_io == 0) ? (a - 32768) / 1024 : -1;
      int e_dev = (slot >= 0) ? (65535 - (1 << slot)) : 65535;
      int e_en  = (slot == 15) ? 0 : 1;
      string ctag;
      if (!valid) ctag = "R3";
      else if (ref_bank != 0) ctag = "R6";
      else if (phase_clk) ctag = "R5";
      else ctag = "R4";
      chk(rst_n ? "R1" : "R2", "bank", b, ref_bank);
      chk("R10", "full_adr", f, ref_bank * 65536 + a);
      chk(ctag, "ram_sel_n", ram, e_ram);
      chk(ctag, "io_sel_n", io, e_io);
      chk(ctag, "rom_sel_n", rom, e_rom);
      chk(valid ? "R7" : "R3", "dev_sel_n", dev, e_dev);
      chk(valid ? "R8" : "R3", "xcvr_en_n", en, e_en);
      chk("R9", "xcvr_to_cpu", dir, int'(cpu_read));
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         if (!rst_n) ref_bank = 0;
         else if (!phase_clk) ref_bank = int'(dbus);
         compare(1'b0, int'(bank_a), int'(full_a), int'(ram_a), int'(io_a),
                 int'(rom_a), int'(dev_a), int'(en_a), int'(dir_a));
         compare(1'b1, int'(bank_b), int'(full_b), int'(ram_b), int'(io_b),
                 int'(rom_b), int'(dev_b), int'(en_b), int'(dir_b));
      end
   end

   // One bus cycle: decoy then bank in the low half, data change in the high half.
   task automatic bus_cycle(logic [7:0] b, logic [15:0] a, logic sd, logic sp,
                            logic rd, logic [7:0] wdata);
      @(posedge clk);
      phase_clk <= 1'b0; adr <= a; dbus <= b ^ 8'hA5;
      dv <= sd; pv <= sp; cpu_read <= rd;
      @(posedge clk);
      dbus <= b;
      @(posedge clk);
      phase_clk <= 1'b1;
      @(posedge clk);
      dbus <= wdata;
      cpu_read <= ~rd;
      @(posedge clk);
      cpu_read <= rd;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      rst_n = 1'b0; phase_clk = 1'b0; cpu_read = 1'b1;
      dv = 1'b0; pv = 1'b0; adr = 16'h0000; dbus = 8'h3C;
      repeat (4) @(posedge clk);            // R2: bank held at 0 under reset
      rst_n <= 1'b1;

      // Sweep the address space with every strobe combination (R3, R4, R5, R7, R8).
      for (int c = 0; c < 4; c++) begin
         for (int i = 0; i < 1024; i++) begin
            bus_cycle(8'h00, 16'(i * 64 + (i % 64)), c[1], c[0], i[0], 8'(i * 7));
         end
      end

      // Region and device boundaries (R4, R7, R8).
      foreach (bounds[k]) bus_cycle(8'h00, bounds[k], 1'b1, 1'b0, k[0], 8'hFF);

      // Every nonzero bank (R6, R10).
      for (int b = 1; b < 256; b++) begin
         bus_cycle(8'(b), 16'(b * 257), b[0], ~b[0], 1'b0, 8'(~b));
      end
      bus_cycle(8'h80, 16'hBC10, 1'b0, 1'b1, 1'b1, 8'h00);  // R6 mirror hits the transceiver slot

      // Reset during the high half, release while still high (R2).
      bus_cycle(8'h42, 16'h1234, 1'b1, 1'b0, 1'b1, 8'h99);
      @(posedge clk) rst_n <= 1'b0;
      repeat (3) @(posedge clk);
      rst_n <= 1'b1;
      repeat (3) @(posedge clk);
      bus_cycle(8'h07, 16'hBC00, 1'b1, 1'b1, 1'b0, 8'h11);
      bus_cycle(8'h00, 16'hBC00, 1'b1, 1'b1, 1'b0, 8'h11);

      @(posedge clk);
      @(negedge clk);
      finished = 1'b1;
      summary();
      $finish;
   end

   logic [15:0] bounds [10] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h83FF, 16'h8400,
                                16'hBBFF, 16'hBC00, 16'hBFFF, 16'hC000, 16'hFFFF};

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         finished = 1'b1;
         summary();
         $finish;
      end
   end

endmodule